// File: doc/BRIEF.md
# Masked Byte Serializer for a GPIO Port

This block loads a serial slave device, such as a configuration-memory input, by shifting bytes out as a clock line and a data line. Both lines live inside one shared 8-bit port output word. A configuration word chooses which port bits act as the clock and which act as the data, and it also sets the bit order. Port bits outside the two masks carry the value of a separate `dout_i` word, so the serializer shares the port with ordinary output logic.

Bytes enter on a valid/ready stream. For each bit, the block pulls the clock pins low, then places the bit on the data pins, then raises the clock pins. Each of these three phases lasts `PHASE_CYC` system clocks, so the slave sees data that has settled before every rising clock edge.

A new configuration goes into a pending slot and takes effect only while the block is idle. At that point it is checked against the current writable-bit mask and the current output-enable mask. A configuration that fails the check is refused and clears both masks. If a byte arrives while either mask is zero, the block takes it from the stream, reports an error and sends nothing.

Top module: `gpio_byte_serializer`

## Requirements
- R1: The configuration word holds the clock pin mask in bits 7:0, the data pin mask in bits 15:8 and a most-significant-bit-first flag in bit 16. Once applied, these appear on `clk_mask_o`, `data_mask_o` and `msb_first_o`.
- R2: A pending configuration is applied when the block is idle, on the clock edge after it was written. It is accepted only if the clock mask and the data mask each share at least one bit with `wr_mask_i` and at least one bit with `oe_i`. Otherwise both masks become zero and `cfg_rej_o` is high for exactly one cycle.
- R3: A configuration written during a transfer, or in the same cycle as an accepted byte, is held until that byte is finished. That byte uses the old configuration. `in_ready_o` stays low while a configuration is pending.
- R4: A byte accepted while either mask is zero raises `byte_err_o` for one cycle, starts no transfer and leaves the port equal to `dout_i`.
- R5: With the flag at 1, the bits of a byte are sent from bit 7 down to bit 0. With the flag at 0, they are sent from bit 0 up to bit 7.
- R6: Each bit is sent in three phases of `PHASE_CYC` cycles each: clock pins low, then data pins set to the bit value, then clock pins high. The data pins do not change at the rising clock edge.
- R7: After a byte handshake, `in_ready_o` stays low for 24*`PHASE_CYC` cycles (8 bits × 3 phases).
- R8: During a transfer, port bits outside both masks keep their value. When the block is idle, those bits follow `dout_i` one cycle later. Selected bits keep their value while idle.
- R9: After reset, `port_o` is 0, both masks and the flag are 0, `in_ready_o` is 1, and both error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 17 | Configuration word (see R1) |
| wr_mask_i | input | 8 | Port bits that may be changed |
| oe_i | input | 8 | Port bits configured as outputs |
| dout_i | input | 8 | Value for the port bits the serializer does not own |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Byte stream ready |
| byte_err_o | output | 1 | Byte refused because a mask is zero |
| cfg_rej_o | output | 1 | Configuration refused |
| clk_mask_o | output | 8 | Applied clock pin mask |
| data_mask_o | output | 8 | Applied data pin mask |
| msb_first_o | output | 1 | Applied bit-order flag |
| port_o | output | 8 | Port output word |

## Verification
A configuration write and a byte handshake can land on the same clock edge, and they are the two events that compete for the idle state. The bench raises `cfg_we_i` and `in_valid_i` on the same negative edge. It then requires that the byte is sent with the old masks and bit order and that the masks stay unchanged during the transfer. The new configuration must appear only after the last clock-high phase, with `in_ready_o` held low one extra cycle. The scoreboard records every rising edge on the clock pin and compares the data pin there against the expected bit, so a byte sent with the wrong configuration shows up as a mismatch.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam int PORT_W = 8;
  localparam int CFG_W  = 2 * PORT_W + 1;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CLK_LO,
    PH_DATA,
    PH_CLK_HI
  } phase_e;

  // field order is the software-visible layout
  typedef struct packed {
    logic              msb_first;
    logic [PORT_W-1:0] dat_mask;
    logic [PORT_W-1:0] clk_mask;
  } cfg_t;
endpackage

// File: rtl/gbs_timer.sv
module gbs_timer #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  generate
    if (PHASE_CYC <= 1) begin : g_single
      assign last_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(PHASE_CYC);
      logic [CW-1:0] cnt_q;
      assign last_o = (cnt_q == CW'(PHASE_CYC - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               cnt_q <= '0;
        else if (!run_i || last_o) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/gbs_shift.sv
module gbs_shift #(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BYTE_BITS-1:0] data_i,
  input  logic                 msb_first_i,
  input  logic                 step_i,
  output logic                 bit_o,
  output logic                 last_bit_o
);
  localparam int IW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;

  logic [BYTE_BITS-1:0] sh_q;
  logic [IW-1:0]        idx_q;
  logic                 msb_q;

  assign bit_o      = msb_q ? sh_q[BYTE_BITS-1] : sh_q[0];
  assign last_bit_o = (idx_q == IW'(BYTE_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
      msb_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
      msb_q <= msb_first_i;
    end else if (step_i) begin
      sh_q  <= msb_q ? (sh_q << 1) : (sh_q >> 1);
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/gbs_cfg.sv
module gbs_cfg
  import gbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  cfg_t              wdata_i,
  input  logic [PORT_W-1:0] wr_mask_i,
  input  logic [PORT_W-1:0] oe_i,
  input  logic              apply_i,
  output cfg_t              cfg_o,
  output logic              pend_o,
  output logic              rej_o
);
  cfg_t pend_q, cfg_q;
  logic pend_v_q, rej_q, ok, do_apply;

  assign ok = (|(pend_q.clk_mask & wr_mask_i)) && (|(pend_q.clk_mask & oe_i)) &&
              (|(pend_q.dat_mask & wr_mask_i)) && (|(pend_q.dat_mask & oe_i));
  assign do_apply = apply_i && pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      cfg_q    <= '0;
      rej_q    <= 1'b0;
    end else begin
      if (we_i) begin
        pend_q   <= wdata_i;
        pend_v_q <= 1'b1;
      end else if (do_apply) begin
        pend_v_q <= 1'b0;
      end
      if (do_apply) begin
        cfg_q.msb_first <= pend_q.msb_first;
        cfg_q.clk_mask  <= ok ? pend_q.clk_mask : '0;
        cfg_q.dat_mask  <= ok ? pend_q.dat_mask : '0;
      end
      rej_q <= do_apply && !ok;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_v_q;
  assign rej_o  = rej_q;
endmodule

// File: rtl/gpio_byte_serializer.sv
module gpio_byte_serializer
  import gbs_pkg::*;
#(
  parameter int PHASE_CYC = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic [PORT_W-1:0]    wr_mask_i,
  input  logic [PORT_W-1:0]    oe_i,
  input  logic [PORT_W-1:0]    dout_i,
  input  logic                 in_valid_i,
  input  logic [BYTE_BITS-1:0] in_data_i,
  output logic                 in_ready_o,
  output logic                 byte_err_o,
  output logic                 cfg_rej_o,
  output logic [PORT_W-1:0]    clk_mask_o,
  output logic [PORT_W-1:0]    data_mask_o,
  output logic                 msb_first_o,
  output logic [PORT_W-1:0]    port_o
);
  phase_e            ph_q;
  cfg_t              cfg;
  logic              pend, busy, accept, masks_ok, start, apply;
  logic              ph_last, step, bit_val, last_bit, err_q;
  logic [PORT_W-1:0] port_q, sel;

  assign busy       = (ph_q != PH_IDLE);
  assign in_ready_o = !busy && !pend;
  assign accept     = in_valid_i && in_ready_o;
  assign masks_ok   = (|cfg.clk_mask) && (|cfg.dat_mask);
  assign start      = accept && masks_ok;
  assign apply      = !busy && !accept;
  assign step       = (ph_q == PH_CLK_HI) && ph_last;
  assign sel        = cfg.clk_mask | cfg.dat_mask;

  gbs_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_t'(cfg_wdata_i)),
    .wr_mask_i(wr_mask_i),
    .oe_i     (oe_i),
    .apply_i  (apply),
    .cfg_o    (cfg),
    .pend_o   (pend),
    .rej_o    (cfg_rej_o)
  );

  gbs_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .last_o(ph_last)
  );

  gbs_shift #(.BYTE_BITS(BYTE_BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .data_i     (in_data_i),
    .msb_first_i(cfg.msb_first),
    .step_i     (step),
    .bit_o      (bit_val),
    .last_bit_o (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      port_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !masks_ok;
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q   <= PH_CLK_LO;
            port_q <= port_q & ~cfg.clk_mask;
          end else begin
            port_q <= (port_q & sel) | (dout_i & ~sel);
          end
        end
        PH_CLK_LO: if (ph_last) begin
          ph_q   <= PH_DATA;
          port_q <= (port_q & ~cfg.dat_mask) | ({PORT_W{bit_val}} & cfg.dat_mask);
        end
        PH_DATA: if (ph_last) begin
          ph_q   <= PH_CLK_HI;
          port_q <= port_q | cfg.clk_mask;
        end
        PH_CLK_HI: if (ph_last) begin
          if (last_bit) begin
            ph_q <= PH_IDLE;
          end else begin
            ph_q   <= PH_CLK_LO;
            port_q <= port_q & ~cfg.clk_mask;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign byte_err_o  = err_q;
  assign port_o      = port_q;
  assign clk_mask_o  = cfg.clk_mask;
  assign data_mask_o = cfg.dat_mask;
  assign msb_first_o = cfg.msb_first;
endmodule

// File: rtl/gbs_checker.sv
module gbs_checker
  import gbs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              byte_err_o,
  input logic              cfg_rej_o,
  input logic [PORT_W-1:0] clk_mask_o,
  input logic [PORT_W-1:0] data_mask_o,
  input logic [PORT_W-1:0] port_o
);
  AST_REJ_CLEARS_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rej_o |-> (clk_mask_o == '0) && (data_mask_o == '0)); // R2
  AST_CFG_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(clk_mask_o) && $stable(data_mask_o)); // R3
  AST_ERR_ON_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_err_o |-> $past(in_valid_i && in_ready_o) && !busy_i); // R4
  AST_DATA_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && $rose(|(port_o & clk_mask_o)))
      |-> $stable(port_o & data_mask_o & ~clk_mask_o)); // R6
  AST_READY_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !in_ready_o); // R7
  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(port_o & ~(clk_mask_o | data_mask_o))); // R8
endmodule

bind gpio_byte_serializer gbs_checker u_gbs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .byte_err_o (byte_err_o),
  .cfg_rej_o  (cfg_rej_o),
  .clk_mask_o (clk_mask_o),
  .data_mask_o(data_mask_o),
  .port_o     (port_o)
);

// File: tb/gpio_byte_serializer_bench.sv
module gpio_byte_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 2;
  localparam int BYTE_CYC   = 24 * PHASE;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [16:0] cfg_wdata_i = '0;
  logic [7:0]  wr_mask_i = 8'hFF;
  logic [7:0]  oe_i = 8'h0F;
  logic [7:0]  dout_i = 8'h00;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, byte_err_o, cfg_rej_o, msb_first_o;
  logic [7:0]  clk_mask_o, data_mask_o, port_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;
  bit   exp_q[$];
  logic [7:0] mon_clk = 8'h00;
  logic [7:0] mon_dat = 8'h00;
  logic [7:0] prev_port = 8'h00;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  gpio_byte_serializer #(.PHASE_CYC(PHASE)) u_gpio_byte_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .wr_mask_i(wr_mask_i), .oe_i(oe_i), .dout_i(dout_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .byte_err_o(byte_err_o),
    .cfg_rej_o(cfg_rej_o), .clk_mask_o(clk_mask_o), .data_mask_o(data_mask_o),
    .msb_first_o(msb_first_o), .port_o(port_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: sample data pins at every rising edge of the clock pins
  always @(negedge clk_i) begin
    if (rst_ni && mon_clk != 8'h00) begin
      if (!(|(prev_port & mon_clk)) && (|(port_o & mon_clk))) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected clock rise", {24'h0, port_o}, 32'h0);
        end else begin
          bit b;
          b = exp_q.pop_front();
          check((port_o & mon_dat) == (b ? mon_dat : 8'h00), "R5 bit value",
                {24'h0, port_o & mon_dat}, {24'h0, b ? mon_dat : 8'h00});
          check((prev_port & mon_dat) == (port_o & mon_dat), "R6 data setup",
                {24'h0, prev_port & mon_dat}, {24'h0, port_o & mon_dat});
        end
      end
    end
    prev_port = port_o;
  end

  task automatic push_bits(input logic [7:0] b, input bit msb);
    for (int i = 0; i < 8; i++) exp_q.push_back(msb ? b[7-i] : b[i]);
  endtask

  task automatic cfg_write(input logic [16:0] w);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = w;
    @(negedge clk_i); cfg_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] b, input bit msb, output int lo_cyc);
    push_bits(b, msb);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = b;
    @(negedge clk_i); in_valid_i = 1'b0;
    lo_cyc = 0;
    while (!in_ready_o) begin lo_cyc++; @(negedge clk_i); end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(port_o == 8'h00 && in_ready_o && !byte_err_o && !cfg_rej_o, "R9 reset outputs",
          {22'h0, port_o, in_ready_o, byte_err_o}, 32'h2);
    check(clk_mask_o == 0 && data_mask_o == 0 && !msb_first_o, "R9 reset cfg",
          {15'h0, msb_first_o, data_mask_o, clk_mask_o}, 32'h0);
    rst_ni = 1'b1;

    // R1 field positions, R2 accept
    cfg_write(17'h0_02_01);
    check(clk_mask_o == 8'h01 && data_mask_o == 8'h02 && !msb_first_o && !cfg_rej_o,
          "R1 R2 accepted cfg", {14'h0, cfg_rej_o, msb_first_o, data_mask_o, clk_mask_o}, 32'h0201);
    mon_clk = 8'h01; mon_dat = 8'h02;

    // R5 lsb-first, R7 ready low time
    send(8'hA5, 1'b0, cyc);
    check(cyc == BYTE_CYC, "R7 ready low cycles", cyc, BYTE_CYC);

    // R8 unselected bits hold during transfer, follow dout when idle
    fork
      send(8'h3C, 1'b0, cyc);
      begin
        repeat (10) @(negedge clk_i);
        dout_i = 8'hF0;
        repeat (5) @(negedge clk_i);
        check((port_o & 8'hFC) == 8'h00, "R8 hold during transfer", {24'h0, port_o}, 32'h0);
      end
    join
    @(negedge clk_i);
    check((port_o & 8'hFC) == 8'hF0, "R8 follow dout when idle", {24'h0, port_o}, 32'hF0);

    // R5 msb-first
    cfg_write(17'h1_02_01);
    check(msb_first_o == 1'b1, "R1 msb flag", {31'h0, msb_first_o}, 32'h1);
    send(8'h1D, 1'b1, cyc);

    // R3 cfg write during transfer is deferred
    fork
      send(8'h5A, 1'b1, cyc);
      begin
        repeat (6) @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_wdata_i = 17'h0_08_04;
        @(negedge clk_i); cfg_we_i = 1'b0;
        repeat (3) @(negedge clk_i);
        check(clk_mask_o == 8'h01 && data_mask_o == 8'h02, "R3 masks held mid-byte",
              {16'h0, data_mask_o, clk_mask_o}, 32'h0201);
      end
    join
    check(cyc == BYTE_CYC + 1, "R3 ready low while pending", cyc, BYTE_CYC + 1);
    check(clk_mask_o == 8'h04 && data_mask_o == 8'h08 && !msb_first_o, "R3 deferred cfg applied",
          {15'h0, msb_first_o, data_mask_o, clk_mask_o}, 32'h0804);
    mon_clk = 8'h04; mon_dat = 8'h08;
    send(8'h96, 1'b0, cyc);

    // R3 cfg write and byte handshake on the same edge
    push_bits(8'h0F, 1'b0);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 8'h0F; cfg_we_i = 1'b1; cfg_wdata_i = 17'h1_02_01;
    @(negedge clk_i); in_valid_i = 1'b0; cfg_we_i = 1'b0;
    repeat (20) @(negedge clk_i);
    check(clk_mask_o == 8'h04 && !msb_first_o, "R3 same-edge byte uses old cfg",
          {23'h0, msb_first_o, clk_mask_o}, 32'h04);
    while (!in_ready_o) @(negedge clk_i);
    check(exp_q.size() == 0, "R3 same-edge byte fully sent", exp_q.size(), 0);
    check(clk_mask_o == 8'h01 && data_mask_o == 8'h02 && msb_first_o, "R3 same-edge cfg applied",
          {15'h0, msb_first_o, data_mask_o, clk_mask_o}, 32'h10201);
    mon_clk = 8'h01; mon_dat = 8'h02;

    // R2 reject: data pin not an output
    cfg_write(17'h0_10_01);
    check(cfg_rej_o && clk_mask_o == 0 && data_mask_o == 0, "R2 reject by oe",
          {15'h0, cfg_rej_o, data_mask_o, clk_mask_o}, 32'h10000);
    mon_clk = 8'h00; mon_dat = 8'h00;
    @(negedge clk_i);
    check(!cfg_rej_o, "R2 reject pulse one cycle", {31'h0, cfg_rej_o}, 0);

    // R4 byte refused with zero masks
    in_valid_i = 1'b1; in_data_i = 8'hFF;
    @(negedge clk_i); in_valid_i = 1'b0;
    check(byte_err_o && in_ready_o, "R4 byte error", {30'h0, byte_err_o, in_ready_o}, 32'h3);
    check(port_o == dout_i, "R4 port unchanged", {24'h0, port_o}, {24'h0, dout_i});
    @(negedge clk_i);
    check(!byte_err_o && port_o == dout_i, "R4 error pulse one cycle",
          {23'h0, byte_err_o, port_o}, {24'h0, dout_i});

    // R2 reject: clock pin not writable
    wr_mask_i = 8'hFE;
    cfg_write(17'h0_02_01);
    check(cfg_rej_o && clk_mask_o == 0, "R2 reject by wr mask",
          {23'h0, cfg_rej_o, clk_mask_o}, 32'h100);
    wr_mask_i = 8'hFF;
    cfg_write(17'h1_02_01);
    check(!cfg_rej_o && clk_mask_o == 8'h01 && data_mask_o == 8'h02, "R2 accept after reject",
          {15'h0, cfg_rej_o, data_mask_o, clk_mask_o}, 32'h0201);
    mon_clk = 8'h01; mon_dat = 8'h02;
    send(8'hE7, 1'b1, cyc);
    check(cyc == BYTE_CYC, "R7 ready low cycles msb", cyc, BYTE_CYC);
    check(exp_q.size() == 0, "R6 all bits clocked", exp_q.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule